// File: doc/BRIEF.md
# Mailbox Interrupt Identifier Arbiter

This block holds one interrupt-pending flag for each of 32 message mailboxes. Mailbox logic raises flags through a per-mailbox set vector. Software lowers a single flag by writing that mailbox's number on a clear port. A priority encoder picks the lowest-numbered pending mailbox. Its 1-based number is latched into an identifier register. A value of zero in that register means no mailbox is pending.

The identifier is returned in a 32-bit read word for the register file. An interrupt request line is raised while the identifier is non-zero and the interrupt enable input is high. Typical service software reads the identifier and handles that mailbox. It then writes the same number to the clear port and repeats until the identifier reads zero.

Top module: `mbox_irq_id_top`

## Requirements
- R1: While `rstN` is low and after its release, `regRdata` reads 0 and `irqLine` is low until a pending flag has been set.
- R2: The identifier occupies `regRdata[23:16]`. Bits 31:24 and 15:0 always read zero.
- R3: An identifier of 0 means no mailbox is pending. Any other value is a mailbox number from 1 to 32. Values 33 and above never appear.
- R4: When several mailboxes are pending, the identifier names the lowest-numbered one.
- R5: A high `setVec[i]` in a cycle marks mailbox i+1 pending. The flag stays pending until that mailbox is cleared.
- R6: `clrEn` high with `clrNum` in 1..32 lowers only mailbox `clrNum`. A `clrNum` of 0 or above 32 changes no flag.
- R7: If the same mailbox is set and cleared in one cycle, it ends up pending.
- R8: The pending flags change on the clock edge that samples a set or clear. The identifier follows on the next edge, one cycle later.
- R9: `irqLine` is high exactly when the identifier is non-zero and `irqEnable` is high. It falls when the identifier reaches 0 or when the enable drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| setVec | input | 32 | Per-mailbox set strobes, bit i for mailbox i+1 |
| clrEn | input | 1 | Clear request strobe |
| clrNum | input | 8 | 1-based number of the mailbox to clear |
| irqEnable | input | 1 | Interrupt line enable |
| regRdata | output | 32 | Read value of the identifier register |
| irqLine | output | 1 | Interrupt request |

## Verification
A set strobe and a clear of the same mailbox can fall in the same cycle. The bench provokes this by clearing the mailbox currently reported while raising its set bit on that same edge. The result is judged by whether the identifier still names that mailbox two edges later.

Clears of other mailboxes and out-of-range clear numbers are also issued alongside pending sets. These cases confirm that only the addressed flag drops.

// File: rtl/mbox_irq_pkg.sv
package mbox_irq_pkg;
  localparam int MBOX_CNT = 32;
  localparam int ID_W     = 8;
  localparam int REG_W    = 32;
  localparam int ID_LSB   = 16;
  localparam int IDX_W    = $clog2(MBOX_CNT);

  // strobes from control to datapath for one cycle
  typedef struct packed {
    logic [MBOX_CNT-1:0] setMask;
    logic [MBOX_CNT-1:0] clrMask;
  } mboxStrobe_t;
endpackage

// File: rtl/mbox_irq_ctrl.sv
module mbox_irq_ctrl
  import mbox_irq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [MBOX_CNT-1:0] setVec,
  input  logic                clrEn,
  input  logic [ID_W-1:0]     clrNum,
  input  logic                irqEnable,
  input  logic                idNonZero,
  output mboxStrobe_t         strb,
  output logic                irqLine
);
  logic            clrHit;
  logic [ID_W-1:0] clrNumM1;
  logic [IDX_W-1:0] clrIdx;

  assign clrHit   = clrEn && (clrNum != '0) && (clrNum <= ID_W'(MBOX_CNT));
  assign clrNumM1 = clrNum - ID_W'(1);
  assign clrIdx   = clrNumM1[IDX_W-1:0];

  always_comb begin
    strb.setMask = setVec;
    strb.clrMask = '0;
    if (clrHit) strb.clrMask[clrIdx] = 1'b1;
  end

  assign irqLine = irqEnable && idNonZero;

  // R6
  clr_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.clrMask));

  // R6
  clr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clrEn || clrNum == '0 || clrNum > ID_W'(MBOX_CNT)) |-> (strb.clrMask == '0));

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !irqEnable |-> !irqLine);
endmodule

// File: rtl/mbox_irq_dp.sv
module mbox_irq_dp
  import mbox_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  mboxStrobe_t strb,
  output logic [ID_W-1:0] idVal,
  output logic        idNonZero
);
  logic [MBOX_CNT-1:0] pendReg;
  logic [ID_W-1:0]     idNext;
  logic [ID_W-1:0]     idReg;

  // set wins over clear on the same flag
  always_ff @(posedge clk) begin
    if (!rstN) pendReg <= '0;
    else       pendReg <= (pendReg & ~strb.clrMask) | strb.setMask;
  end

  // lowest-numbered pending mailbox wins
  always_comb begin
    idNext = '0;
    for (int i = MBOX_CNT - 1; i >= 0; i--)
      if (pendReg[i]) idNext = ID_W'(i + 1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) idReg <= '0;
    else       idReg <= idNext;
  end

  assign idVal     = idReg;
  assign idNonZero = (idReg != '0);

  // ---- checking state (not part of the function)
  logic [MBOX_CNT-1:0] pendSeen;
  logic                pastValid;
  logic [ID_W-1:0]     idM1;
  logic [IDX_W-1:0]    idIdx;
  logic [MBOX_CNT-1:0] lowMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendSeen  <= '0;
      pastValid <= 1'b0;
    end else begin
      pendSeen  <= pendReg;
      pastValid <= 1'b1;
    end
  end

  assign idM1    = idReg - ID_W'(1);
  assign idIdx   = idM1[IDX_W-1:0];
  assign lowMask = (MBOX_CNT'(1) << idIdx) - MBOX_CNT'(1);

  // R3
  id_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    idReg <= ID_W'(MBOX_CNT));

  // R3
  id_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (idReg == '0) |-> (pendSeen == '0));

  // R4
  id_prio_chk: assert property (@(posedge clk) disable iff (!rstN)
    (idReg != '0 && idReg <= ID_W'(MBOX_CNT)) |->
      (pendSeen[idIdx] && ((pendSeen & lowMask) == '0)));

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    pastValid |-> (($past(strb.setMask) & ~pendReg) == '0));
endmodule

// File: rtl/mbox_irq_id_top.sv
module mbox_irq_id_top
  import mbox_irq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [MBOX_CNT-1:0] setVec,
  input  logic                clrEn,
  input  logic [ID_W-1:0]     clrNum,
  input  logic                irqEnable,
  output logic [REG_W-1:0]    regRdata,
  output logic                irqLine
);
  mboxStrobe_t     strb;
  logic [ID_W-1:0] idVal;
  logic            idNonZero;

  mbox_irq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .setVec(setVec), .clrEn(clrEn), .clrNum(clrNum),
    .irqEnable(irqEnable), .idNonZero(idNonZero), .strb(strb), .irqLine(irqLine)
  );

  mbox_irq_dp dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .idVal(idVal), .idNonZero(idNonZero)
  );

  assign regRdata = {{(REG_W-ID_LSB-ID_W){1'b0}}, idVal, {ID_LSB{1'b0}}};

  // R2
  field_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRdata[REG_W-1:ID_LSB+ID_W] == '0) && (regRdata[ID_LSB-1:0] == '0));

  // R9
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqLine == (irqEnable && regRdata[ID_LSB+ID_W-1:ID_LSB] != '0)));
endmodule

// File: tb/mbox_irq_id_top_tb_top.sv
module mbox_irq_id_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] setVec;
  logic        clrEn;
  logic [7:0]  clrNum;
  logic        irqEnable;
  logic [31:0] regRdata;
  logic        irqLine;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_irq_id_top dut_i (
    .clk(clk), .rstN(rstN), .setVec(setVec), .clrEn(clrEn), .clrNum(clrNum),
    .irqEnable(irqEnable), .regRdata(regRdata), .irqLine(irqLine)
  );

  typedef struct packed {
    logic [31:0] setV;
    logic        clrE;
    logic [7:0]  clrN;
    logic        en;
    logic [7:0]  expId;
    logic        expIrq;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{32'h0000_0000, 1'b0, 8'd0,  1'b1, 8'd0,  1'b0},  // R3 nothing pending
    '{32'h0000_0010, 1'b0, 8'd0,  1'b1, 8'd5,  1'b1},  // R5 set mbox 5
    '{32'h8000_0000, 1'b0, 8'd0,  1'b1, 8'd5,  1'b1},  // R4 mbox 5 beats 32
    '{32'h0000_0000, 1'b1, 8'd5,  1'b1, 8'd32, 1'b1},  // R6 clear 5
    '{32'h0000_0000, 1'b0, 8'd0,  1'b0, 8'd32, 1'b0},  // R9 enable low
    '{32'h0000_0001, 1'b0, 8'd0,  1'b0, 8'd1,  1'b0},  // R4 mbox 1 wins
    '{32'h0000_0000, 1'b1, 8'd40, 1'b1, 8'd1,  1'b1},  // R6 out-of-range clear
    '{32'h0000_0001, 1'b1, 8'd1,  1'b1, 8'd1,  1'b1},  // R7 set wins
    '{32'h0000_0000, 1'b1, 8'd1,  1'b1, 8'd32, 1'b1},  // R6 clear 1
    '{32'h0000_0000, 1'b1, 8'd32, 1'b1, 8'd0,  1'b0}   // R9 id back to 0
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic checkOut(input string req, input logic [7:0] expId, input logic expIrq);
    chk({req, " id"}, regRdata, {8'h00, expId, 16'h0000});  // R2 layout
    chk({req, " irq"}, {31'd0, irqLine}, {31'd0, expIrq});
  endtask

  // one stimulus cycle, then an idle cycle so the identifier has caught up (R8)
  task automatic step(input logic [31:0] s, input logic ce, input logic [7:0] cn, input logic en);
    @(negedge clk);
    setVec = s; clrEn = ce; clrNum = cn; irqEnable = en;
    @(posedge clk);
    @(negedge clk);
    setVec = '0; clrEn = 1'b0; clrNum = '0;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [7:0] lowestId(input logic [31:0] p);
    logic [7:0] r = 8'd0;
    for (int i = 31; i >= 0; i--) if (p[i]) r = 8'(i + 1);
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] model;
    rstN = 1'b0; setVec = '0; clrEn = 1'b0; clrNum = '0; irqEnable = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkOut("R1 in reset", 8'd0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R1 after reset", 8'd0, 1'b0);

    for (int v = 0; v < NVEC; v++) begin
      step(VECS[v].setV, VECS[v].clrE, VECS[v].clrN, VECS[v].en);
      checkOut($sformatf("vector %0d", v), VECS[v].expId, VECS[v].expIrq);
    end

    // R8: identifier lags the pending flag by one cycle
    @(negedge clk);
    setVec = 32'h0000_0400; irqEnable = 1'b1;
    @(posedge clk); @(negedge clk);
    setVec = '0;
    checkOut("R8 first edge", 8'd0, 1'b0);
    @(posedge clk); @(negedge clk);
    checkOut("R8 second edge", 8'd11, 1'b1);

    // R6: clear of a non-pending mailbox leaves mbox 11
    step(32'h0, 1'b1, 8'd3, 1'b1);
    checkOut("R6 clear other", 8'd11, 1'b1);
    // R6: clrNum without clrEn ignored
    step(32'h0, 1'b0, 8'd11, 1'b1);
    checkOut("R6 no enable", 8'd11, 1'b1);
    step(32'h0, 1'b1, 8'd0, 1'b1);
    checkOut("R6 number zero", 8'd11, 1'b1);
    step(32'h0, 1'b1, 8'd11, 1'b1);
    checkOut("R9 cleared", 8'd0, 1'b0);

    // R4/R5 random patterns drained one at a time against a model
    model = '0;
    for (int it = 0; it < 8; it++) begin
      logic [31:0] s;
      s = $urandom;
      if (it == 0) s = 32'hFFFF_FFFF;
      step(s, 1'b0, 8'd0, 1'b1);
      model |= s;
      checkOut("R5 random set", lowestId(model), model != 0);
      for (int k = 0; k < 32 && model != 0; k++) begin
        logic [7:0] id;
        id = lowestId(model);
        step(32'h0, 1'b1, id, 1'b1);
        model[id - 8'd1] = 1'b0;
        checkOut("R4 drain", lowestId(model), model != 0);
      end
    end

    // R1: reset mid-run clears pending state
    step(32'h0001_0000, 1'b0, 8'd0, 1'b1);
    checkOut("R5 pre-reset", 8'd17, 1'b1);
    @(negedge clk); rstN = 1'b0;
    @(posedge clk); @(negedge clk);
    checkOut("R1 mid reset", 8'd0, 1'b0);
    rstN = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    checkOut("R1 post reset", 8'd0, 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule